// File: doc/BRIEF.md
# Sparse Channel-Vector Dot-Product Engine

The engine takes a window of up to nine feature vectors, each with a paired weight vector, and reduces them to one number. Every vector carries sixteen channel lanes that are processed side by side. A feature vector whose lanes are all zero is dropped when the window is loaded, so it never occupies a multiplier cycle. On each cycle after the load, the lowest-indexed remaining vector is issued together with its weight vector. The sixteen lane products are summed by a binary adder tree, and that partial sum is then folded into the result. Depending on the mode, the fold either adds the partial sum to a running total or keeps the largest partial sum seen.

A kernel of any shape is handled as a series of such windows. Each window covers a group of 1x1x16 spatial steps and is loaded with a one-cycle start pulse. The done flag stays high and the result stays stable until the next start. Elements are signed and are interpreted as either 16-bit or 8-bit values. In 8-bit mode only the low byte of each 16-bit lane is used, and the upper byte is ignored.

Top module: `sparse_dot_engine`

## Requirements
- R1: After reset, done is 0 and result is 0.
- R2: A feature vector whose lanes are all zero, judged at the selected precision, contributes nothing to the result in either mode, whatever its weight vector holds.
- R3: Each issued pair contributes the signed sum of its sixteen lane products.
- R4: With mode_max=0 the result is the sum of the partial sums of all non-zero feature vectors, starting from 0.
- R5: With mode_max=1 the result is the largest partial sum among the non-zero feature vectors. A window with no non-zero vector returns the most negative value of the result width, which is -2^39 at default parameters.
- R6: With prec16=1 each lane is a signed 16-bit value. With prec16=0 each lane is the signed value of bits [7:0], and bits [15:8] have no effect, including on the zero test.
- R7: Count the clock edge that samples start as edge 0, and let N be the number of non-zero feature vectors. Done is first high after edge N+1 when N>0, and after edge 0 when N=0. It is low in every cycle in between.
- R8: Once done is high and no start arrives, done stays high and result holds its value.
- R9: No overflow occurs at the extreme operands. For example, nine vectors with every lane at -32768 on both operands accumulate to 9*16*2^30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads a window and clears the result |
| mode_max | input | 1 | 0: accumulate, 1: running maximum (sampled with start) |
| prec16 | input | 1 | 1: 16-bit lanes, 0: 8-bit lanes in bits [7:0] (sampled with start) |
| fm_win | input | 2304 | Nine feature vectors; lane l of vector v is at bits [(v*16+l)*16 +: 16] |
| wt_win | input | 2304 | Nine weight vectors, same layout as fm_win |
| result | output | 40 | Signed accumulated sum or maximum |
| done | output | 1 | Result final for the loaded window |

## Verification
The bench runs every one of the 512 zero patterns of the nine feature vectors, in both modes and at both precisions, with random operands. For each run it checks both the value and the exact cycle in which done rises. A skip path that counts a zero vector, or misses the lowest pending index, shows up as a wrong sum or a latency that is off by one or more cycles. In 8-bit mode the zero vectors carry junk in their upper bytes. A design that tests all sixteen bits would therefore issue those vectors, and both the latency and the sum would go wrong. The extreme-operand cases, and max mode with only negative partial sums, expose a tree or accumulator that is too narrow, or a maximum that starts from 0 instead of the most negative value.

// File: rtl/sparse_dot_engine.sv
module sparse_dot_engine #(
  parameter int LANES = 16,
  parameter int DEPTH = 9,
  parameter int EW    = 16,
  localparam int VW   = LANES * EW,
  localparam int SW   = 2 * EW + $clog2(LANES),
  localparam int ACCW = SW + $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   mode_max,
  input  logic                   prec16,
  input  logic [DEPTH*VW-1:0]    fm_win,
  input  logic [DEPTH*VW-1:0]    wt_win,
  output logic signed [ACCW-1:0] result,
  output logic                   done
);
  localparam logic signed [ACCW-1:0] ACC_MIN = {1'b1, {(ACCW-1){1'b0}}};

  function automatic logic signed [EW-1:0] lane_val(input logic [EW-1:0] x, input logic p16);
    return p16 ? x : {{(EW-8){x[7]}}, x[7:0]};
  endfunction

  logic [VW-1:0] fm_q [DEPTH];
  logic [VW-1:0] wt_q [DEPTH];
  logic [DEPTH-1:0] pend, gnt, nz_in;
  logic mode_q, prec_q, pv, loaded;
  logic signed [SW-1:0] psum_q;
  logic signed [ACCW-1:0] acc;
  logic [VW-1:0] sel_fm, sel_wt;
  logic signed [SW-1:0] tree [2*LANES-1];

  always_comb begin
    for (int v = 0; v < DEPTH; v++) begin
      nz_in[v] = 1'b0;
      for (int l = 0; l < LANES; l++)
        nz_in[v] = nz_in[v] | (lane_val(fm_win[(v*LANES+l)*EW +: EW], prec16) != '0);
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    gnt = '0;
    sel_fm = '0;
    sel_wt = '0;
    for (int v = 0; v < DEPTH; v++) begin
      if (pend[v] && !found) begin
        gnt[v] = 1'b1;
        found = 1'b1;
        sel_fm = fm_q[v];
        sel_wt = wt_q[v];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_leaf
    assign tree[LANES-1+l] = SW'(lane_val(sel_fm[l*EW +: EW], prec_q) *
                                lane_val(sel_wt[l*EW +: EW], prec_q));
  end
  for (genvar n = 0; n < LANES-1; n++) begin : g_node
    assign tree[n] = tree[2*n+1] + tree[2*n+2];
  end

  logic signed [ACCW-1:0] psum_x;
  assign psum_x = ACCW'(psum_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= '0;
      pv     <= 1'b0;
      psum_q <= '0;
      acc    <= '0;
      mode_q <= 1'b0;
      prec_q <= 1'b0;
      loaded <= 1'b0;
    end else if (start) begin
      for (int v = 0; v < DEPTH; v++) begin
        fm_q[v] <= fm_win[v*VW +: VW];
        wt_q[v] <= wt_win[v*VW +: VW];
      end
      pend   <= nz_in;
      pv     <= 1'b0;
      mode_q <= mode_max;
      prec_q <= prec16;
      acc    <= mode_max ? ACC_MIN : '0;
      loaded <= 1'b1;
    end else begin
      pv <= |pend;
      if (|pend) begin
        pend   <= pend & ~gnt;
        psum_q <= tree[0];
      end
      if (pv)
        acc <= mode_q ? ((psum_x > acc) ? psum_x : acc) : acc + psum_x;
    end
  end

  assign result = acc;
  assign done   = loaded && (pend == '0) && !pv;
endmodule

// File: rtl/sparse_dot_engine_chk.sv
module sparse_dot_engine_chk #(
  parameter int DEPTH = 9,
  parameter int ACCW  = 40
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   mode_q,
  input logic [DEPTH-1:0]       pend,
  input logic [DEPTH-1:0]       gnt,
  input logic                   pv,
  input logic                   done,
  input logic signed [ACCW-1:0] result
);
  a_r2_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~pend) == '0));

  a_r7_one_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0 && !start) |=> ($countones(pend) + 1 == $countones($past(pend))));

  a_r7_issue_feeds_pipe: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0 && !start) |=> pv);

  a_r5_max_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !start) |=> (result >= $past(result)));

  a_r8_hold_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result)));
endmodule

bind sparse_dot_engine sparse_dot_engine_chk #(.DEPTH(DEPTH), .ACCW(ACCW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .mode_q(mode_q), .pend(pend),
  .gnt(gnt), .pv(pv), .done(done), .result(result)
);

// File: tb/sparse_dot_engine_tb_top.sv
module sparse_dot_engine_tb_top;
  localparam int LANES = 16, DEPTH = 9, EW = 16, ACCW = 40;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_max = 1'b0, prec16 = 1'b0;
  logic [DEPTH*LANES*EW-1:0] fm_win = '0, wt_win = '0;
  logic signed [ACCW-1:0] result;
  logic done;
  int total = 0, bad = 0;
  logic [15:0] fmv [DEPTH][LANES];
  logic [15:0] wtv [DEPTH][LANES];

  always #10 clk = ~clk;

  sparse_dot_engine dut_i (.clk(clk), .rst_n(rst_n), .start(start), .mode_max(mode_max),
    .prec16(prec16), .fm_win(fm_win), .wt_win(wt_win), .result(result), .done(done));

  function automatic longint eff(input logic [15:0] x, input logic p);
    return p ? longint'($signed(x)) : longint'($signed(x[7:0]));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic md, input logic p, input string req);
    longint exp, ps;
    int n, cyc;
    logic [ACCW-1:0] held;
    exp = md ? -(longint'(1) <<< (ACCW-1)) : 0;
    n = 0;
    for (int v = 0; v < DEPTH; v++) begin
      logic nz;
      nz = 1'b0;
      ps = 0;
      for (int l = 0; l < LANES; l++) begin
        if (eff(fmv[v][l], p) != 0) nz = 1'b1;
        ps += eff(fmv[v][l], p) * eff(wtv[v][l], p);
        fm_win[(v*LANES+l)*EW +: EW] = fmv[v][l];
        wt_win[(v*LANES+l)*EW +: EW] = wtv[v][l];
      end
      if (nz) begin
        n++;
        if (md) exp = (ps > exp) ? ps : exp;
        else exp += ps;
      end
    end
    mode_max = md; prec16 = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check({req, " R7 latency"}, cyc, (n == 0) ? 0 : n + 1);
    check({req, " R3/R4/R5 result"}, longint'(result), exp);
    held = result;
    @(negedge clk);
    @(negedge clk);
    check({req, " R8 hold"}, {longint'(done), longint'(result == held)}, {64'd1, 64'd1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset done", longint'(done), 0);
    check("R1 reset result", longint'(result), 0);

    // R2 R4 R5 R6: every zero pattern, both modes, both precisions
    for (int p = 0; p < 2; p++)
      for (int md = 0; md < 2; md++)
        for (int mask = 0; mask < (1 << DEPTH); mask++) begin
          for (int v = 0; v < DEPTH; v++)
            for (int l = 0; l < LANES; l++) begin
              wtv[v][l] = 16'($urandom);
              if (mask[v]) begin
                fmv[v][l] = 16'($urandom);
                if (l == 0 && fmv[v][l][7:0] == 8'd0) fmv[v][l][7:0] = 8'd3;
              end else begin
                fmv[v][l] = p ? 16'd0 : {8'($urandom), 8'd0};
              end
            end
          run(md[0], p[0], "R2 R6 sweep");
        end

    // R9: extremes
    for (int v = 0; v < DEPTH; v++)
      for (int l = 0; l < LANES; l++) begin fmv[v][l] = 16'h8000; wtv[v][l] = 16'h8000; end
    run(1'b0, 1'b1, "R9 16b extreme");
    check("R9 16b value", longint'(result), 64'd9 * 16 * (64'd1 << 30));
    for (int v = 0; v < DEPTH; v++)
      for (int l = 0; l < LANES; l++) begin fmv[v][l] = 16'h7F80; wtv[v][l] = 16'h0080; end
    run(1'b0, 1'b0, "R9 8b extreme");
    check("R9 8b value", longint'(result), 64'd9 * 16 * 16384);

    // R5: only negative partial sums
    for (int v = 0; v < DEPTH; v++)
      for (int l = 0; l < LANES; l++) begin
        fmv[v][l] = (v == 4) ? 16'd1 : 16'd0;
        wtv[v][l] = 16'hFFFF;
      end
    run(1'b1, 1'b1, "R5 negative max");
    check("R5 negative max value", longint'(result), -16);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule